// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block inspects the lowest 16-bit parcel of an instruction and reports how many 16-bit parcels the whole instruction occupies. A fetch or alignment stage uses the count to find where the next instruction starts, and it needs no later parcel to do so. The result is purely combinational, with no state and no clock.

A static scheme input selects one of two length conventions. Scheme 0 uses a unary run of low ones up to 64 bits, then a 3-bit count in bits [14:12] for 80 bits and longer. Scheme 1 uses bits [6:5] to select the 48, 64 and 80-bit lengths, then bits [14:12] for 96 bits and longer. In both schemes, the all-ones value of the count field is an escape for longer encodings. The block flags that escape as reserved and does not report a length for it. The scheme input is a configuration strap and is held steady while instructions are decoded.

Top module: `ild_len_decode`

## Requirements
- R1: When parcel bits [1:0] are not 2'b11, the length is 1 parcel with valid high and reserved low, in both schemes.
- R2: When bits [1:0] are 2'b11 and bits [4:2] are not 3'b111, the length is 2 parcels, in both schemes.
- R3: In scheme 0 (scheme_i = 0) with bits [4:0] = 5'b11111, bit 5 = 0 gives 3 parcels, and bits [6:5] = 2'b01 give 4 parcels.
- R4: In scheme 0, bits [6:0] = 7'h7F give 5 + bits[14:12] parcels (5 to 11). Bits [14:12] = 3'b111 are the reserved escape.
- R5: In scheme 1 (scheme_i = 1) with bits [4:0] = 5'b11111, bits [6:5] = 2'b00, 2'b01 and 2'b10 give 3, 4 and 5 parcels.
- R6: In scheme 1, bits [6:0] = 7'h7F give 6 + bits[14:12] parcels (6 to 12). Bits [14:12] = 3'b111 are the reserved escape.
- R7: For a reserved escape, len_o is 0, valid_o is low and reserved_o is high. For every other parcel, valid_o is high and reserved_o is low.
- R8: Parcel bit 15 and bits [11:7] have no effect on any output in either scheme.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| parcel_i | input | 16 | Lowest 16-bit parcel of the instruction |
| scheme_i | input | 1 | Static length-convention select (0 or 1) |
| len_o | output | 4 | Instruction length in 16-bit parcels, or 0 when reserved |
| valid_o | output | 1 | High when len_o holds a defined length |
| reserved_o | output | 1 | High for the escape pattern of the selected scheme |

## Verification
No register lies between parcel_i or scheme_i and any output, so every result is due in the same cycle as its stimulus. The bench drives a new parcel just after a rising edge and checks len_o, valid_o and reserved_o at the next falling edge, which leaves half a period for the outputs to settle. The sweep covers all 65536 parcels under both schemes. The ignored-bit checks apply two parcels in successive cycles and compare the two results, each sampled at its own falling edge.

// File: rtl/ild_pkg.sv
package ild_pkg;
  localparam int PARCEL_W    = 16;
  localparam int LEN_W       = 4;
  localparam int NUM_SCHEMES = 2;
  localparam int FUNCT_LSB   = 12;
  localparam int FUNCT_W     = 3;
  localparam int SEL_LSB     = 5;
  localparam int SEL_W       = 2;
  localparam int CLS_W       = 5;

  // First long length (in parcels) of each scheme when the count field applies
  localparam int UNARY_EXT_BASE = 5;
  localparam int FUNCT_EXT_BASE = 6;

  typedef enum logic [1:0] {
    CLS_HALF = 2'd0,
    CLS_WORD = 2'd1,
    CLS_LONG = 2'd2
  } size_cls_e;

  // Length in parcels for a count-field instruction
  function automatic logic [LEN_W-1:0] ext_len(input int base, input logic [FUNCT_W-1:0] funct);
    ext_len = LEN_W'(base) + LEN_W'(funct);
  endfunction

  // The all-ones count value is the escape to longer encodings
  function automatic logic is_escape(input logic [FUNCT_W-1:0] funct);
    is_escape = &funct;
  endfunction

  // Length for one of the select-coded mid sizes (3 parcels upward)
  function automatic logic [LEN_W-1:0] mid_len(input int step);
    mid_len = LEN_W'(3 + step);
  endfunction
endpackage

// File: rtl/ild_size_class.sv
module ild_size_class
  import ild_pkg::*;
(
  input  logic [CLS_W-1:0] low_i,
  output size_cls_e        cls_o
);
  logic half_w;
  logic word_w;

  assign half_w = (low_i[1:0] != 2'b11);
  assign word_w = !half_w && (low_i[4:2] != 3'b111);

  always_comb begin
    if (half_w)      cls_o = CLS_HALF;
    else if (word_w) cls_o = CLS_WORD;
    else             cls_o = CLS_LONG;
  end
endmodule

// File: rtl/ild_unary_scheme.sv
module ild_unary_scheme
  import ild_pkg::*;
(
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output logic [LEN_W-1:0]   len_o,
  output logic               rsv_o
);
  logic count_mode_w;

  assign count_mode_w = (sel_i == 2'b11);

  always_comb begin
    rsv_o = 1'b0;
    if (!sel_i[0]) begin
      len_o = mid_len(0);
    end else if (!count_mode_w) begin
      len_o = mid_len(1);
    end else if (is_escape(funct_i)) begin
      len_o = '0;
      rsv_o = 1'b1;
    end else begin
      len_o = ext_len(UNARY_EXT_BASE, funct_i);
    end
  end

  always_comb begin
    if (!rsv_o) begin
      AST_UNARY_RANGE: assert (len_o >= 4'd3 && len_o <= 4'd11) else $error("unary length out of range"); // R4
    end
    if (!sel_i[0]) begin
      AST_UNARY_SHORTEST: assert (len_o == 4'd3 && !rsv_o) else $error("unary 3-parcel wrong"); // R3
    end
  end
endmodule

// File: rtl/ild_funct_scheme.sv
module ild_funct_scheme
  import ild_pkg::*;
(
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output logic [LEN_W-1:0]   len_o,
  output logic               rsv_o
);
  logic count_mode_w;

  assign count_mode_w = &sel_i;

  always_comb begin
    rsv_o = 1'b0;
    if (!count_mode_w) begin
      len_o = mid_len(int'(sel_i));
    end else if (is_escape(funct_i)) begin
      len_o = '0;
      rsv_o = 1'b1;
    end else begin
      len_o = ext_len(FUNCT_EXT_BASE, funct_i);
    end
  end

  always_comb begin
    if (!rsv_o) begin
      AST_FUNCT_RANGE: assert (len_o >= 4'd3 && len_o <= 4'd12) else $error("count length out of range"); // R6
    end
    if (count_mode_w && !rsv_o) begin
      AST_FUNCT_LONG_MIN: assert (len_o >= 4'd6) else $error("long length below 6"); // R6
    end
  end
endmodule

// File: rtl/ild_len_decode.sv
module ild_len_decode
  import ild_pkg::*;
(
  input  logic [PARCEL_W-1:0] parcel_i,
  input  logic                scheme_i,
  output logic [LEN_W-1:0]    len_o,
  output logic                valid_o,
  output logic                reserved_o
);
  size_cls_e        cls_w;
  logic [LEN_W-1:0] sch_len [NUM_SCHEMES];
  logic             sch_rsv [NUM_SCHEMES];
  logic             unused_bits;

  // Bits outside the length fields never reach the result
  assign unused_bits = ^{parcel_i[15], parcel_i[11:7]};

  ild_size_class u_cls (
    .low_i (parcel_i[CLS_W-1:0]),
    .cls_o (cls_w)
  );

  for (genvar g = 0; g < NUM_SCHEMES; g++) begin : g_sch
    if (g == 0) begin : g_unary
      ild_unary_scheme u_dec (
        .sel_i   (parcel_i[SEL_LSB +: SEL_W]),
        .funct_i (parcel_i[FUNCT_LSB +: FUNCT_W]),
        .len_o   (sch_len[g]),
        .rsv_o   (sch_rsv[g])
      );
    end else begin : g_funct
      ild_funct_scheme u_dec (
        .sel_i   (parcel_i[SEL_LSB +: SEL_W]),
        .funct_i (parcel_i[FUNCT_LSB +: FUNCT_W]),
        .len_o   (sch_len[g]),
        .rsv_o   (sch_rsv[g])
      );
    end
  end

  always_comb begin
    len_o      = '0;
    valid_o    = 1'b1;
    reserved_o = 1'b0;
    case (cls_w)
      CLS_HALF: len_o = 4'd1;
      CLS_WORD: len_o = 4'd2;
      default: begin
        if (sch_rsv[scheme_i]) begin
          valid_o    = 1'b0;
          reserved_o = 1'b1;
        end else begin
          len_o = sch_len[scheme_i];
        end
      end
    endcase
  end

  always_comb begin
    if (parcel_i[1:0] != 2'b11) begin
      AST_HALF_LEN: assert (len_o == 4'd1 && valid_o) else $error("16-bit length wrong"); // R1
    end
    if (parcel_i[1:0] == 2'b11 && parcel_i[4:2] != 3'b111) begin
      AST_WORD_LEN: assert (len_o == 4'd2 && valid_o) else $error("32-bit length wrong"); // R2
    end
    AST_FLAG_EXCL: assert (valid_o != reserved_o) else $error("valid and reserved agree"); // R7
    if (reserved_o) begin
      AST_RSV_ZERO: assert (len_o == '0) else $error("reserved with length"); // R7
      AST_RSV_ONLY_ESC: assert (parcel_i[6:0] == 7'h7F && parcel_i[14:12] == 3'b111)
        else $error("reserved outside escape"); // R7
    end
  end
endmodule

// File: tb/sim_ild_len_decode.sv
module sim_ild_len_decode;
  logic        clk = 1'b0;
  logic [15:0] parcel;
  logic        scheme;
  logic [3:0]  len;
  logic        valid;
  logic        rsv;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;

  ild_len_decode u0 (
    .parcel_i   (parcel),
    .scheme_i   (scheme),
    .len_o      (len),
    .valid_o    (valid),
    .reserved_o (rsv)
  );

  // Count of consecutive ones from bit 0, up to 7
  function automatic int low_ones(input logic [15:0] p);
    int t = 0;
    while (t < 7 && p[t]) t++;
    return t;
  endfunction

  // Expected {len, valid, reserved} restated from the requirements
  function automatic logic [5:0] model(input logic s, input logic [15:0] p);
    int t = low_ones(p);
    int f = int'(p[14:12]);
    int k = int'(p[6:5]);
    int n;
    if (t < 2) n = 1;
    else if (t < 5) n = 2;
    else if (!s) begin
      if (t == 5) n = 3;
      else if (t == 6) n = 4;
      else n = (f == 7) ? 0 : 5 + f;
    end else begin
      if (k < 3) n = 3 + k;
      else n = (f == 7) ? 0 : 6 + f;
    end
    return {4'(n), (n != 0), (n == 0)};
  endfunction

  function automatic string tag_of(input logic s, input logic [15:0] p);
    int t = low_ones(p);
    if (t < 2) return "R1";
    if (t < 5) return "R2";
    if (p[14:12] == 3'b111 && p[6:0] == 7'h7F) return s ? "R6 R7" : "R4 R7";
    if (!s) return (t == 7) ? "R4" : "R3";
    return (p[6:5] == 2'b11) ? "R6" : "R5";
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp,
                       input logic s, input logic [15:0] p);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s scheme=%0d parcel=%h actual len=%0d v=%0d r=%0d expected len=%0d v=%0d r=%0d",
               req, s, p, act[5:2], act[1], act[0], exp[5:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input logic s, input logic [15:0] p);
    @(posedge clk);
    scheme = s;
    parcel = p;
    @(negedge clk);
  endtask

  initial begin
    logic [5:0] first;
    parcel = 16'h0000;
    scheme = 1'b0;
    @(negedge clk);
    check("R1", {len, valid, rsv}, 6'b0001_10, 1'b0, 16'h0000); // initial state

    // Full sweep of every parcel under both schemes
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 65536; p++) begin
        apply(1'(s), 16'(p));
        check(tag_of(1'(s), 16'(p)), {len, valid, rsv}, model(1'(s), 16'(p)), 1'(s), 16'(p));
      end
    end

    // R8: toggling bit 15 and bits [11:7] leaves every output unchanged
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 64; i++) begin
        logic [15:0] base;
        logic [15:0] flip;
        base = 16'(i * 1031 + 16'h007F * (i % 3)) & 16'h707F;
        flip = base | (16'(i * 37) & 16'h8F80) | 16'h0080;
        apply(1'(s), base);
        first = {len, valid, rsv};
        apply(1'(s), flip);
        check("R8", {len, valid, rsv}, first, 1'(s), flip);
      end
    end

    // Explicit boundary lengths
    apply(1'b0, 16'h607F); check("R4", {len, valid, rsv}, 6'b1011_10, 1'b0, 16'h607F);
    apply(1'b1, 16'h607F); check("R6", {len, valid, rsv}, 6'b1100_10, 1'b1, 16'h607F);
    apply(1'b1, 16'h705F); check("R5", {len, valid, rsv}, 6'b0101_10, 1'b1, 16'h705F);
    apply(1'b0, 16'h707F); check("R7", {len, valid, rsv}, 6'b0000_01, 1'b0, 16'h707F);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule